// File: doc/BRIEF.md
# Five-Core Staggered Fill Scheduler and Best-Vector Selector

This block sits between one shared external memory read port and five block-matching search cores: a centre core and four sector cores. It fills the cores' local memories one core at a time, always in the same rotation. For each beat it tells the memory which core, which beat offset and which block index are being served, and it forwards the returned beat to the selected core. When a core's fill completes, that core gets a start pulse and searches on its own while the next core is being filled. Once the centre core for the next block is due, its refill overlaps the search work of the sector cores. In steady state the cores stay busy and one block completes every five fill windows.

Each core reports a SAD and a motion vector when it finishes. The block keeps two banks of results, one for even block indices and one for odd. When all five results of the oldest open block are present, it picks the smallest SAD and emits that core's vector tagged with the block index. A core is not refilled while it is still searching, or while its result from two blocks earlier has not been consumed. The cycles lost this way are counted.

Top module: `penta_fill_sched`

## Requirements
- R1: After a synchronous active-low reset, `req_valid`, `fill_we`, `core_start` and `best_valid` are 0 and `stall_cnt` is 0.
- R2: Each core fill is 34 consecutive cycles with `req_valid` high. `req_offset` counts 0 to 33 for one fixed `req_core`. `fill_we` is one-hot on bit `req_core`, and `fill_data` equals `strm_data` in the same cycle.
- R3: Cores are filled in the order 0 (centre), 1, 2, 3, 4, then 0 again. `req_blk` starts at 0 and increments by one after core 4's fill.
- R4: `core_start` is one-hot on a core in the cycle right after that core's offset-33 beat, and is 0 in every other cycle.
- R5: When no core is held off, the next core's offset-0 beat follows the previous core's offset-33 beat directly, so blocks complete every 170 cycles.
- R6: A core's fill is not started while that core is searching, or while its result for the block two indices earlier is still unconsumed. `stall_cnt` increments, saturating, for each cycle the scheduler waits on such a core with `run` high.
- R7: A result is emitted when all five cores have reported for the oldest open block. `best_valid` pulses two cycles after the cycle in which the last of those `core_done` pulses was high.
- R8: The emitted result is the lowest SAD of the five. On equal SADs the lower core index wins (centre first). `best_core`, `best_sad`, `best_mvx` and `best_mvy` come from that core.
- R9: `best_idx` equals the `req_blk` value under which the block was filled, and results leave in block order.
- R10: While `run` is low, no core fill is started. A fill already under way completes, and filling resumes with the next core in the rotation.
- R11: A `core_done` pulse from a core that is not searching is ignored. It produces no result and does not alter any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Permits new core fills to start |
| strm_data | input | 272 | Memory beat for the current request (34 bytes) |
| req_valid | output | 1 | A fill beat is requested this cycle |
| req_core | output | 3 | Core being filled (0 centre, 1..4 sectors) |
| req_offset | output | 6 | Beat offset within the core's fill, 0..33 |
| req_blk | output | 8 | Block index of the fill |
| fill_we | output | 5 | One-hot write enable to the cores |
| fill_data | output | 272 | Beat forwarded to the cores |
| core_start | output | 5 | One-cycle search start per core |
| core_done | input | 5 | One-cycle search done per core |
| core_sad | input | 80 | Per-core SAD, core c at bits [16c+15:16c] |
| core_mvx | input | 40 | Per-core horizontal vector, 8 bits per core |
| core_mvy | input | 40 | Per-core vertical vector, 8 bits per core |
| stall_cnt | output | 16 | Saturating count of held-off cycles |
| best_valid | output | 1 | Result pulse |
| best_core | output | 3 | Winning core |
| best_sad | output | 16 | Winning SAD |
| best_mvx | output | 8 | Winning horizontal vector |
| best_mvy | output | 8 | Winning vertical vector |
| best_idx | output | 8 | Block index of the result |

## Verification
Fill beats appear in the same cycle the sequencer state shows them, so each beat is compared at the falling edge of its own cycle against the expected core, offset, block and data. The start pulse is expected exactly one cycle after a core's offset-33 beat. A result is due two cycles after the last `core_done` of its block: one register records the done and one registers the choice. The scoreboard compares each popped result's arrival cycle against the recorded done cycle plus two. With equal search latencies, it also requires consecutive results to be exactly 170 cycles apart.

// File: rtl/fss_pkg.sv
// Package: shared types for the five-core fill scheduler.
// Assumes: nothing beyond the parameters of the modules that import it.
package fss_pkg;
    typedef enum logic [0:0] {
        FS_WAIT = 1'b0,
        FS_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/fss_fill_seq.sv
// Module: fss_fill_seq
// Steps the shared memory port through the cores in a fixed rotation, one
// fill window of FILL_BEATS beats per core. A core is entered only when it
// is neither searching nor holding an unconsumed result of the same bank.
// Assumes: memory returns a beat in the same cycle it is requested.
module fss_fill_seq
    import fss_pkg::*;
#(
    parameter int NUM_CORES  = 5,
    parameter int FILL_BEATS = 34,
    parameter int IDX_W      = 8,
    parameter int STALL_W    = 16,
    localparam int CW        = $clog2(NUM_CORES),
    localparam int OW        = $clog2(FILL_BEATS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [NUM_CORES-1:0] searching,
    input  logic [NUM_CORES-1:0] pend_even,
    input  logic [NUM_CORES-1:0] pend_odd,
    output logic                 req_valid,
    output logic [CW-1:0]        req_core,
    output logic [OW-1:0]        req_offset,
    output logic [IDX_W-1:0]     req_blk,
    output logic                 fill_last,
    output logic [STALL_W-1:0]   stall_cnt
);
    localparam logic [OW-1:0] LAST_BEAT = OW'(FILL_BEATS - 1);
    localparam logic [CW-1:0] LAST_CORE = CW'(NUM_CORES - 1);

    fill_state_e         state;
    logic [CW-1:0]       cur;
    logic [OW-1:0]       beat;
    logic [IDX_W-1:0]    blk;
    logic [STALL_W-1:0]  stall;
    logic [CW-1:0]       nxt_core;
    logic [IDX_W-1:0]    nxt_blk;
    logic                ok_cur;
    logic                ok_next;

    // A core may be filled for bank par only if idle and its bank slot is free.
    function automatic logic can_fill(input logic [CW-1:0] core, input logic par,
                                      input logic [NUM_CORES-1:0] srch,
                                      input logic [NUM_CORES-1:0] pe,
                                      input logic [NUM_CORES-1:0] po);
        logic res;
        res = 1'b0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (core == CW'(c)) res = !srch[c] && !(par ? po[c] : pe[c]);
        end
        return res;
    endfunction

    // Work out the following core, its block and whether both are free.
    always_comb begin
        nxt_core = (cur == LAST_CORE) ? '0 : cur + 1'b1;
        nxt_blk  = (cur == LAST_CORE) ? blk + 1'b1 : blk;
        ok_cur   = can_fill(cur, blk[0], searching, pend_even, pend_odd);
        ok_next  = can_fill(nxt_core, nxt_blk[0], searching, pend_even, pend_odd);
    end

    // Fill state machine: wait for a free core, then stream its window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_WAIT;
            cur   <= '0;
            beat  <= '0;
            blk   <= '0;
            stall <= '0;
        end else begin
            case (state)
                FS_WAIT: begin
                    if (run) begin
                        if (ok_cur) begin
                            state <= FS_FILL;
                            beat  <= '0;
                        end else if (stall != '1) begin
                            stall <= stall + 1'b1;
                        end
                    end
                end
                default: begin
                    if (beat == LAST_BEAT) begin
                        beat  <= '0;
                        cur   <= nxt_core;
                        blk   <= nxt_blk;
                        state <= (run && ok_next) ? FS_FILL : FS_WAIT;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
            endcase
        end
    end

    assign req_valid  = (state == FS_FILL);
    assign req_core   = cur;
    assign req_offset = beat;
    assign req_blk    = blk;
    assign fill_last  = (state == FS_FILL) && (beat == LAST_BEAT);
    assign stall_cnt  = stall;

    // R2: inside a window offsets advance by one on the same core.
    p_offset_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_offset != '0) |->
            ($past(req_valid) && req_offset == $past(req_offset) + 1'b1
             && req_core == $past(req_core)));

    // R3: a window that directly follows another serves the next core.
    p_core_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_offset == '0 && $past(req_valid)) |->
            ($past(req_offset) == LAST_BEAT &&
             req_core == (($past(req_core) == LAST_CORE) ? '0 : $past(req_core) + 1'b1)));

    // R6: the stall count never goes backwards.
    p_stall_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt >= $past(stall_cnt));
endmodule

// File: rtl/fss_core_track.sv
// Module: fss_core_track
// Tracks which cores are searching and holds their reported results in two
// banks selected by block-index parity, so that a block's results can wait
// while the next block's cores are already refilled and searching.
// Assumes: a core reports at most once per start; stray reports are dropped.
module fss_core_track #(
    parameter int NUM_CORES = 5,
    parameter int SAD_W     = 16,
    parameter int MV_W      = 8,
    localparam int CW       = $clog2(NUM_CORES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fill_last,
    input  logic [CW-1:0]                fill_core,
    input  logic                         fill_par,
    input  logic [NUM_CORES-1:0]         core_done,
    input  logic [NUM_CORES*SAD_W-1:0]   core_sad,
    input  logic [NUM_CORES*MV_W-1:0]    core_mvx,
    input  logic [NUM_CORES*MV_W-1:0]    core_mvy,
    input  logic                         sel_par,
    input  logic                         clr_fire,
    output logic [NUM_CORES-1:0]         searching,
    output logic [NUM_CORES-1:0]         pend_even,
    output logic [NUM_CORES-1:0]         pend_odd,
    output logic                         sel_full,
    output logic [NUM_CORES*SAD_W-1:0]   sel_sad,
    output logic [NUM_CORES*MV_W-1:0]    sel_mvx,
    output logic [NUM_CORES*MV_W-1:0]    sel_mvy
);
    logic [NUM_CORES-1:0]       core_par;
    logic [NUM_CORES*SAD_W-1:0] sad_e, sad_o;
    logic [NUM_CORES*MV_W-1:0]  mvx_e, mvx_o, mvy_e, mvy_o;

    // Search and bank-occupancy flags per core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            searching <= '0;
            core_par  <= '0;
            pend_even <= '0;
            pend_odd  <= '0;
        end else begin
            if (clr_fire) begin
                if (sel_par) pend_odd  <= '0;
                else         pend_even <= '0;
            end
            for (int c = 0; c < NUM_CORES; c++) begin
                if (fill_last && fill_core == CW'(c)) begin
                    searching[c] <= 1'b1;
                    core_par[c]  <= fill_par;
                end else if (core_done[c] && searching[c]) begin
                    searching[c] <= 1'b0;
                    if (core_par[c]) pend_odd[c]  <= 1'b1;
                    else             pend_even[c] <= 1'b1;
                end
            end
        end
    end

    // Result payload capture into the bank of the block the core searched.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CORES; c++) begin
            if (core_done[c] && searching[c]) begin
                if (core_par[c]) begin
                    sad_o[c*SAD_W +: SAD_W] <= core_sad[c*SAD_W +: SAD_W];
                    mvx_o[c*MV_W +: MV_W]   <= core_mvx[c*MV_W +: MV_W];
                    mvy_o[c*MV_W +: MV_W]   <= core_mvy[c*MV_W +: MV_W];
                end else begin
                    sad_e[c*SAD_W +: SAD_W] <= core_sad[c*SAD_W +: SAD_W];
                    mvx_e[c*MV_W +: MV_W]   <= core_mvx[c*MV_W +: MV_W];
                    mvy_e[c*MV_W +: MV_W]   <= core_mvy[c*MV_W +: MV_W];
                end
            end
        end
    end

    assign sel_full = sel_par ? (&pend_odd) : (&pend_even);
    assign sel_sad  = sel_par ? sad_o : sad_e;
    assign sel_mvx  = sel_par ? mvx_o : mvx_e;
    assign sel_mvy  = sel_par ? mvy_o : mvy_e;

    // R11: a bank slot only fills from a done that ended a live search.
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
        p_pend_needs_search_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pend_even[g]) || $rose(pend_odd[g])) |->
                ($past(searching[g]) && $past(core_done[g])));
    end
endmodule

// File: rtl/fss_min_pick.sv
// Module: fss_min_pick
// Combinational pick of the smallest SAD among the cores; on equal values
// the lowest core index is kept because only a strictly smaller value wins.
// Assumes: SAD values are unsigned.
module fss_min_pick #(
    parameter int NUM_CORES = 5,
    parameter int SAD_W     = 16,
    localparam int CW       = $clog2(NUM_CORES)
) (
    input  logic [NUM_CORES*SAD_W-1:0] sad_flat,
    output logic [CW-1:0]              win_core,
    output logic [SAD_W-1:0]           win_sad
);
    // Linear scan from the centre core outward.
    always_comb begin
        win_core = '0;
        win_sad  = sad_flat[SAD_W-1:0];
        for (int c = 1; c < NUM_CORES; c++) begin
            if (sad_flat[c*SAD_W +: SAD_W] < win_sad) begin
                win_sad  = sad_flat[c*SAD_W +: SAD_W];
                win_core = CW'(c);
            end
        end
    end
endmodule

// File: rtl/penta_fill_sched.sv
// Module: penta_fill_sched (top)
// Shares one memory read port among five search cores by filling them in a
// fixed rotation, starts each core when its fill ends, and emits the best
// vector of each block once all cores have reported, tagged with its index.
// Assumes: memory data for a request is on strm_data in the request cycle.
module penta_fill_sched #(
    parameter int NUM_CORES  = 5,
    parameter int FILL_BEATS = 34,
    parameter int BEAT_BYTES = 34,
    parameter int SAD_W      = 16,
    parameter int MV_W       = 8,
    parameter int IDX_W      = 8,
    parameter int STALL_W    = 16,
    localparam int CW        = $clog2(NUM_CORES),
    localparam int OW        = $clog2(FILL_BEATS),
    localparam int DW        = BEAT_BYTES * 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [DW-1:0]               strm_data,
    output logic                        req_valid,
    output logic [CW-1:0]               req_core,
    output logic [OW-1:0]               req_offset,
    output logic [IDX_W-1:0]            req_blk,
    output logic [NUM_CORES-1:0]        fill_we,
    output logic [DW-1:0]               fill_data,
    output logic [NUM_CORES-1:0]        core_start,
    input  logic [NUM_CORES-1:0]        core_done,
    input  logic [NUM_CORES*SAD_W-1:0]  core_sad,
    input  logic [NUM_CORES*MV_W-1:0]   core_mvx,
    input  logic [NUM_CORES*MV_W-1:0]   core_mvy,
    output logic [STALL_W-1:0]          stall_cnt,
    output logic                        best_valid,
    output logic [CW-1:0]               best_core,
    output logic [SAD_W-1:0]            best_sad,
    output logic [MV_W-1:0]             best_mvx,
    output logic [MV_W-1:0]             best_mvy,
    output logic [IDX_W-1:0]            best_idx
);
    logic                       fill_last;
    logic [NUM_CORES-1:0]       searching, pend_even, pend_odd;
    logic                       sel_full;
    logic [NUM_CORES*SAD_W-1:0] sel_sad;
    logic [NUM_CORES*MV_W-1:0]  sel_mvx, sel_mvy;
    logic [CW-1:0]              win_core;
    logic [SAD_W-1:0]           win_sad;
    logic [IDX_W-1:0]           sel_idx;

    fss_fill_seq #(
        .NUM_CORES(NUM_CORES), .FILL_BEATS(FILL_BEATS),
        .IDX_W(IDX_W), .STALL_W(STALL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .searching(searching), .pend_even(pend_even), .pend_odd(pend_odd),
        .req_valid(req_valid), .req_core(req_core), .req_offset(req_offset),
        .req_blk(req_blk), .fill_last(fill_last), .stall_cnt(stall_cnt)
    );

    fss_core_track #(
        .NUM_CORES(NUM_CORES), .SAD_W(SAD_W), .MV_W(MV_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .fill_last(fill_last), .fill_core(req_core), .fill_par(req_blk[0]),
        .core_done(core_done), .core_sad(core_sad),
        .core_mvx(core_mvx), .core_mvy(core_mvy),
        .sel_par(sel_idx[0]), .clr_fire(sel_full),
        .searching(searching), .pend_even(pend_even), .pend_odd(pend_odd),
        .sel_full(sel_full), .sel_sad(sel_sad),
        .sel_mvx(sel_mvx), .sel_mvy(sel_mvy)
    );

    fss_min_pick #(
        .NUM_CORES(NUM_CORES), .SAD_W(SAD_W)
    ) u_pick (
        .sad_flat(sel_sad), .win_core(win_core), .win_sad(win_sad)
    );

    // One write enable per core, steered by the sequencer.
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_we
        assign fill_we[g] = req_valid && (req_core == CW'(g));
    end
    assign fill_data = strm_data;

    // Start pulse to the core whose window just ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_start <= '0;
        end else begin
            for (int c = 0; c < NUM_CORES; c++) begin
                core_start[c] <= fill_last && (req_core == CW'(c));
            end
        end
    end

    // Register the chosen result and advance the block being collected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_valid <= 1'b0;
            best_core  <= '0;
            best_sad   <= '0;
            best_mvx   <= '0;
            best_mvy   <= '0;
            best_idx   <= '0;
            sel_idx    <= '0;
        end else begin
            best_valid <= sel_full;
            if (sel_full) begin
                best_core <= win_core;
                best_sad  <= win_sad;
                best_mvx  <= sel_mvx[win_core*MV_W +: MV_W];
                best_mvy  <= sel_mvy[win_core*MV_W +: MV_W];
                best_idx  <= sel_idx;
                sel_idx   <= sel_idx + 1'b1;
            end
        end
    end

    // Checker state: index of the previous result.
    logic [IDX_W-1:0] chk_prev_idx;
    logic             chk_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_prev_idx <= '0;
            chk_seen     <= 1'b0;
        end else if (best_valid) begin
            chk_prev_idx <= best_idx;
            chk_seen     <= 1'b1;
        end
    end

    // R9: results leave in consecutive block order.
    p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (best_valid && chk_seen) |-> best_idx == chk_prev_idx + 1'b1);

    // R4: a start pulse only follows the final beat of a window.
    p_start_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start != '0) |-> ($past(fill_last) && $onehot(core_start)));
endmodule

// File: tb/penta_fill_sched_bench.sv
module penta_fill_sched_bench;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic [271:0] strm_data;
    logic         req_valid;
    logic [2:0]   req_core;
    logic [5:0]   req_offset;
    logic [7:0]   req_blk;
    logic [4:0]   fill_we;
    logic [271:0] fill_data;
    logic [4:0]   core_start;
    logic [4:0]   core_done = '0;
    logic [79:0]  core_sad = '0;
    logic [39:0]  core_mvx = '0;
    logic [39:0]  core_mvy = '0;
    logic [15:0]  stall_cnt;
    logic         best_valid;
    logic [2:0]   best_core;
    logic [15:0]  best_sad;
    logic [7:0]   best_mvx, best_mvy, best_idx;

    penta_fill_sched u_penta_fill_sched (
        .clk(clk), .rst_n(rst_n), .run(run), .strm_data(strm_data),
        .req_valid(req_valid), .req_core(req_core), .req_offset(req_offset),
        .req_blk(req_blk), .fill_we(fill_we), .fill_data(fill_data),
        .core_start(core_start), .core_done(core_done), .core_sad(core_sad),
        .core_mvx(core_mvx), .core_mvy(core_mvy), .stall_cnt(stall_cnt),
        .best_valid(best_valid), .best_core(best_core), .best_sad(best_sad),
        .best_mvx(best_mvx), .best_mvy(best_mvy), .best_idx(best_idx)
    );

    always #4 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0, nres = 0;
    bit finished = 0;
    bit run_s = 0;
    always @(posedge clk) begin
        cyc++;
        run_s = run;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [271:0] pat(input logic [7:0] b, input logic [2:0] c,
                                         input logic [5:0] o);
        logic [7:0] v;
        v = b * 8'd31 + {5'd0, c} * 8'd7 + {2'd0, o};
        return {34{v}};
    endfunction

    always_comb strm_data = pat(req_blk, req_core, req_offset);

    // Expected results and per-block stub data
    typedef struct { int idx; int core; int sad; int mvx; int mvy; } exp_t;
    exp_t q[$];
    int sad_tab[16][5];
    int last_done[16];
    int lat[5];

    task automatic plan_block(input int b);
        int k, w;
        exp_t e;
        k = b % 7;
        case (k)
            0: begin sad_tab[b] = '{900, 700, 800, 300, 500}; w = 3; end
            1: begin sad_tab[b] = '{400, 400, 400, 400, 400}; w = 0; end
            2: begin sad_tab[b] = '{600, 500, 250, 700, 250}; w = 2; end
            3: begin sad_tab[b] = '{800, 900, 700, 600, 100}; w = 4; end
            4: begin sad_tab[b] = '{65535, 65535, 65535, 65535, 65535}; w = 0; end
            5: begin sad_tab[b] = '{500, 120, 900, 120, 130}; w = 1; end
            default: begin sad_tab[b] = '{10, 0, 0, 0, 0}; w = 1; end
        endcase
        e.idx = b; e.core = w; e.sad = sad_tab[b][w];
        e.mvx = (w * 5 - b) & 255; e.mvy = (b * 3 + w) & 255;
        q.push_back(e);
    endtask

    // Core stubs: start on core_start, report after lat[c] cycles
    int  cnt[5];
    bit  act[5];
    int  sblk[5];
    int  spur = -1;
    always @(negedge clk) begin
        core_done = '0;
        for (int c = 0; c < N; c++) begin
            if (act[c]) begin
                if (cnt[c] == 0) begin
                    core_done[c] = 1'b1;
                    core_sad[c*16 +: 16] = 16'(sad_tab[sblk[c]][c]);
                    core_mvx[c*8 +: 8] = 8'(c * 5 - sblk[c]);
                    core_mvy[c*8 +: 8] = 8'(sblk[c] * 3 + c);
                    act[c] = 0;
                    last_done[sblk[c]] = cyc;
                end else begin
                    cnt[c]--;
                end
            end
            if (core_start[c]) begin
                act[c] = 1;
                cnt[c] = lat[c] - 1;
            end
        end
        if (spur >= 0) begin
            core_done[spur] = 1'b1;
            core_sad[spur*16 +: 16] = 16'd0;
            spur = -1;
        end
    end

    // Fill monitor: beat sequence, data and start pulses
    int  exp_core = 0, exp_off = 0, exp_blk = 0;
    bit  prev_last = 0;
    int  prev_core = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_last || core_start != 0)
                check(core_start == (prev_last ? (5'd1 << prev_core) : 5'd0),
                      "R4", "core_start", core_start, prev_last ? (1 << prev_core) : 0);
            if (req_valid) begin
                check(req_core == 3'(exp_core) && req_blk == 8'(exp_blk), "R3",
                      "core*256+blk", req_core * 256 + req_blk, exp_core * 256 + exp_blk);
                check(req_offset == 6'(exp_off) && fill_we == (5'd1 << exp_core)
                      && fill_data == pat(8'(exp_blk), 3'(exp_core), 6'(exp_off)),
                      "R2", "offset", req_offset, exp_off);
                if (fill_we[req_core] && act[req_core])
                    check(0, "R6", "fill of searching core", req_core, -1);
                if (req_offset == 0) begin
                    if (!run_s) check(0, "R10", "fill started with run low", req_core, -1);
                    sblk[req_core] = req_blk;
                end
                if (exp_off == 33) begin
                    exp_off = 0;
                    if (exp_core == 4) begin exp_core = 0; exp_blk++; end
                    else exp_core++;
                end else begin
                    exp_off++;
                end
            end
            prev_last = req_valid && req_offset == 6'd33;
            prev_core = req_core;
        end
    end

    // Result monitor (scoreboard)
    int last_best = 0;
    always @(negedge clk) begin
        if (rst_n && !finished && best_valid) begin
            if (q.size() == 0) begin
                check(0, "R11", "unexpected result idx", best_idx, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(best_idx == 8'(e.idx), "R9", "best_idx", best_idx, e.idx);
                check(best_core == 3'(e.core) && best_sad == 16'(e.sad), "R8",
                      "core*65536+sad", best_core * 65536 + best_sad, e.core * 65536 + e.sad);
                check(best_mvx == 8'(e.mvx) && best_mvy == 8'(e.mvy), "R8",
                      "mvx*256+mvy", best_mvx * 256 + best_mvy, e.mvx * 256 + e.mvy);
                check(cyc - last_done[e.idx] == 2, "R7", "result latency",
                      cyc - last_done[e.idx], 2);
                if (e.idx >= 1 && e.idx <= 5)
                    check(cyc - last_best == 170, "R5", "block period", cyc - last_best, 170);
                last_best = cyc;
                nres++;
            end
        end
    end

    task automatic run_until(input int lastblk);
        @(posedge clk); #1 run = 1'b1;
        do begin @(posedge clk); #1; end
        while (!(req_valid && req_core == 3'd4 && req_blk == 8'(lastblk)));
        run = 1'b0;
    endtask

    task automatic wait_results(input int n);
        while (nres < n) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(0, "WDOG", "run did not complete, results", nres, 13);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < N; c++) lat[c] = 20;
        for (int b = 0; b < 13; b++) plan_block(b);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid && fill_we == 0 && core_start == 0, "R1", "req/we/start idle",
              {req_valid, fill_we, core_start}, 0);
        check(!best_valid && stall_cnt == 0, "R1", "best_valid/stall", stall_cnt, 0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(!req_valid, "R10", "request while run low", req_valid, 0);

        // Blocks 0..5 with equal short latencies: back-to-back, no stall
        run_until(5);
        wait_results(6);
        check(stall_cnt == 0, "R6", "stall with free cores", stall_cnt, 0);

        // Block 6 paused after core 2, resumed with core 3
        @(posedge clk); #1 run = 1'b1;
        do begin @(posedge clk); #1; end
        while (!(req_valid && req_core == 3'd2 && req_blk == 8'd6));
        run = 1'b0;
        repeat (80) @(posedge clk);
        @(negedge clk);
        check(!req_valid, "R10", "request during pause", req_valid, 0);
        run_until(7);
        wait_results(8);
        check(stall_cnt == 0, "R6", "stall after pause", stall_cnt, 0);

        // Slow centre core: refill must be held off and counted
        lat[0] = 260;
        run_until(10);
        wait_results(11);
        check(stall_cnt > 0, "R6", "stall count with slow centre", stall_cnt, 1);
        lat[0] = 20;

        // Stray done on an idle core, then two more blocks
        @(posedge clk); #1 spur = 2;
        repeat (12) @(posedge clk);
        check(nres == 11, "R11", "results after stray done", nres, 11);
        run_until(12);
        wait_results(13);
        check(q.size() == 0, "R9", "results outstanding", q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule